// File: doc/BRIEF.md
# Four-Digit Decimal Event Counter with Seven-Segment Outputs

This block counts enabled clock events in decimal across a chain of decade stages and presents every stage directly as a seven-segment pattern. No external decoder is needed. The lowest stage advances on each enabled cycle. A higher stage advances on the same edge at which every stage below it rolls from 9 back to 0. Each stage holds a four-bit value that stays within 0..9.

An optional mode turns off the display of leading zeros. When it is on, a zero digit is dark if it is a leading digit, meaning it and every digit above it are zero. The lowest digit is never dark, so a total of zero still shows a single 0. When the whole count rolls from its maximum (all nines) back to zero, a one-cycle overflow pulse is produced.

The number of digits is the parameter `NUM_DIGITS`, with a default of 4.

Top module: `dec_seg_counter`

## Requirements
- R1: While `rst` is high at a clock edge, every digit becomes 0 and `ovf` is low on the following cycle. With `blank_en` low, every display then shows the zero pattern 7'b1110111.
- R2: When `cnt_en` is high at a clock edge, the lowest digit goes up by one and wraps from 9 to 0. When `cnt_en` is low, no digit changes.
- R3: A digit above the lowest one advances only when `cnt_en` is high and every lower digit equals 9. On that same edge it goes from 9 to 0 if it was 9.
- R4: Segment bit order is: 0 top, 1 upper-left, 2 upper-right, 3 middle, 4 lower-left, 5 lower-right, 6 bottom. Displays are packed into `seg_out` with digit k (k=0 is least significant) at bits [7k+6:7k].
- R5: The patterns, written bit6..bit0, are: 0=1110111, 1=0100100, 2=1011101, 3=1101101, 4=0101110, 5=1101011, 6=1111011, 7=0100101, 8=1111111, 9=1101111.
- R6: With `blank_en` high, digit k (k≥1) shows 7'b0000000 when it and all digits above it are zero. Digit 0 is never blanked. A nonzero digit, or a zero digit with a nonzero digit above it, shows its normal pattern.
- R7: `ovf` is high for exactly the one cycle after the edge at which the count wraps from 9999 to 0000. At all other times it is low.
- R8: `blank_en` affects only the display. It never changes the stored count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count one event this cycle |
| blank_en | input | 1 | Enable leading-zero blanking |
| seg_out | output | 7*NUM_DIGITS | Packed segment patterns, digit 0 in low bits |
| ovf | output | 1 | One-cycle pulse on full wrap |

## Verification
The bench builds the block with the default of four digits. This makes the full 0000→9999→0000 wrap reachable in 10000 enabled cycles, well inside the run budget. That reach lets the bench check the carry rippling through every stage, the overflow pulse and all blanking depths on real counts. Expected displays come from a decimal model in the bench that is converted to patterns with the table in R5.

// File: rtl/dec_seg_pkg.sv
package dec_seg_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    localparam bcd_t BCD_MAX = 4'd9;
    localparam seg_t SEG_OFF = 7'b0000000;

    typedef struct packed {
        logic top;
        logic up_l;
        logic up_r;
        logic mid;
        logic lo_l;
        logic lo_r;
        logic bot;
    } seg_named_t;

    // Per-segment OR of the digit values that light it.
    function automatic seg_t bcd_to_seg(input bcd_t v);
        logic [9:0] hot;
        seg_named_t s;
        hot = 10'd0;
        if (v <= BCD_MAX) hot[v] = 1'b1;
        s.top  = hot[0] | hot[2] | hot[3] | hot[5] | hot[6] | hot[7] | hot[8] | hot[9];
        s.up_l = hot[0] | hot[4] | hot[5] | hot[6] | hot[8] | hot[9];
        s.up_r = hot[0] | hot[1] | hot[2] | hot[3] | hot[4] | hot[7] | hot[8] | hot[9];
        s.mid  = hot[2] | hot[3] | hot[4] | hot[5] | hot[6] | hot[8] | hot[9];
        s.lo_l = hot[0] | hot[2] | hot[6] | hot[8];
        s.lo_r = hot[0] | hot[1] | hot[3] | hot[4] | hot[5] | hot[6] | hot[7] | hot[8] | hot[9];
        s.bot  = hot[0] | hot[2] | hot[3] | hot[5] | hot[6] | hot[8] | hot[9];
        return {s.bot, s.lo_r, s.lo_l, s.mid, s.up_r, s.up_l, s.top};
    endfunction

endpackage

// File: rtl/dec_seg_stage.sv
module dec_seg_stage
    import dec_seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output bcd_t digit,
    output logic at_max
);
    bcd_t val_q;

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= '0;
        else if (adv)
            val_q <= (val_q == BCD_MAX) ? bcd_t'(0) : val_q + bcd_t'(1);
    end

    assign digit  = val_q;
    assign at_max = (val_q == BCD_MAX);

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        val_q <= BCD_MAX); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(val_q)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv && val_q == BCD_MAX) |=> val_q == 4'd0); // R3
endmodule

// File: rtl/dec_seg_blank.sv
module dec_seg_blank
    import dec_seg_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                    blank_en,
    input  bcd_t [NUM_DIGITS-1:0]   digits,
    output logic [7*NUM_DIGITS-1:0] seg_out
);
    // lead_zero[k]: digit k and all above are zero
    logic [NUM_DIGITS-1:0] lead_zero;

    generate
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
            if (k == NUM_DIGITS - 1) begin : g_top
                assign lead_zero[k] = (digits[k] == 4'd0);
            end else begin : g_rest
                assign lead_zero[k] = (digits[k] == 4'd0) && lead_zero[k+1];
            end
            if (k == 0) begin : g_low
                assign seg_out[6:0] = bcd_to_seg(digits[0]);
            end else begin : g_hi
                assign seg_out[7*k+6:7*k] = (blank_en && lead_zero[k]) ? SEG_OFF
                                                                     : bcd_to_seg(digits[k]);
            end
        end
    endgenerate

    always_comb begin
        AST_LOW_LIT: assert (seg_out[6:0] != SEG_OFF); // R6
    end
endmodule

// File: rtl/dec_seg_counter.sv
module dec_seg_counter
    import dec_seg_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_en,
    input  logic                    blank_en,
    output logic [7*NUM_DIGITS-1:0] seg_out,
    output logic                    ovf
);
    bcd_t [NUM_DIGITS-1:0] digits;
    logic [NUM_DIGITS-1:0] at_max;
    logic [NUM_DIGITS:0]   carry;   // carry[k]: stage k advances
    logic                  ovf_q;

    assign carry[0] = cnt_en;

    generate
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
            dec_seg_stage u_stage (
                .clk    (clk),
                .rst    (rst),
                .adv    (carry[k]),
                .digit  (digits[k]),
                .at_max (at_max[k])
            );
            assign carry[k+1] = carry[k] & at_max[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= carry[NUM_DIGITS];
    end
    assign ovf = ovf_q;

    dec_seg_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
        .blank_en (blank_en),
        .digits   (digits),
        .seg_out  (seg_out)
    );

    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf); // R7
    AST_OVF_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> digits == '0); // R7
    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(digits)); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (digits == '0 && !ovf)); // R1
endmodule

// File: tb/dec_seg_counter_bench.sv
module dec_seg_counter_bench;
    localparam int ND = 4;

    logic clk = 0, rst = 1, cnt_en = 0, blank_en = 0;
    logic [7*ND-1:0] seg_out;
    logic ovf;
    int tests = 0, fails = 0;
    int model = 0;
    int ovf_seen;
    bit done = 0;

    always #5 clk = ~clk;

    dec_seg_counter #(.NUM_DIGITS(ND)) u_dec_seg_counter (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .blank_en(blank_en),
        .seg_out(seg_out), .ovf(ovf));

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'b1110111; 1: return 7'b0100100; 2: return 7'b1011101;
            3: return 7'b1101101; 4: return 7'b0101110; 5: return 7'b1101011;
            6: return 7'b1111011; 7: return 7'b0100101; 8: return 7'b1111111;
            default: return 7'b1101111;
        endcase
    endfunction

    function automatic logic [7*ND-1:0] expect_seg(input int v, input bit blk);
        logic [7*ND-1:0] r;
        int dig;
        bit lead;
        lead = 1;
        for (int k = ND - 1; k >= 0; k--) begin
            dig = (v / (10 ** k)) % 10;
            if (dig != 0) lead = 0;
            r[7*k +: 7] = (blk && lead && k != 0) ? 7'b0 : pat(dig);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle; drive after negedge, sample ovf after posedge
    task automatic step(input bit en);
        @(negedge clk);
        cnt_en = en;
        @(posedge clk);
        #1;
        if (en) model = (model + 1) % 10000;
        cnt_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; cnt_en = 0;
        @(posedge clk); #1; rst = 0; model = 0;
    endtask

    task automatic t_reset();
        blank_en = 0;
        do_reset();
        chk("R1 seg", {4'd0, seg_out}, {4'd0, {4{7'b1110111}}});
        chk("R1 ovf", {31'd0, ovf}, 32'd0);
    endtask

    task automatic t_patterns();
        blank_en = 0;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            chk("R5 R4 digit0", {25'd0, seg_out[6:0]}, {25'd0, pat(i)});
            chk("R4 full", {4'd0, seg_out}, {4'd0, expect_seg(model, 0)});
            step(1);
        end
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) step(0);
        chk("R2 hold", {4'd0, seg_out}, {4'd0, expect_seg(model, 0)});
    endtask

    task automatic t_carry_and_blank();
        do_reset();
        ovf_seen = 0;
        for (int i = 0; i < 10000; i++) begin
            step(1);
            if (ovf) ovf_seen++;
            if (model == 10 || model == 100 || model == 1000 || model == 1990 || model == 9999)
                chk("R3 carry", {4'd0, seg_out}, {4'd0, expect_seg(model, 0)});
            if (model == 9999)
                chk("R7 no ovf early", {31'd0, ovf}, 32'd0);
            if (model == 0)
                chk("R7 ovf pulse", {31'd0, ovf}, 32'd1);
        end
        step(0);
        chk("R7 ovf drop", {31'd0, ovf}, 32'd0);
        chk("R7 single pulse", ovf_seen, 1);
    endtask

    task automatic t_blank();
        do_reset();
        blank_en = 1; #1;
        chk("R6 zero shows 0", {4'd0, seg_out}, {4'd0, 21'd0, 7'b1110111});
        for (int i = 0; i < 1005; i++) begin
            step(1);
            if (model == 7 || model == 40 || model == 305 || model == 1000 || model == 1004)
                chk("R6 blank", {4'd0, seg_out}, {4'd0, expect_seg(model, 1)});
        end
        blank_en = 0; #1;
        chk("R8 count kept", {4'd0, seg_out}, {4'd0, expect_seg(model, 0)});
        blank_en = 1; step(1);
        blank_en = 0; #1;
        chk("R8 counted while blanked", {4'd0, seg_out}, {4'd0, expect_seg(1006, 0)});
    endtask

    initial begin
        #100000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_patterns();
        t_hold();
        t_carry_and_blank();
        t_blank();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule